// File: doc/BRIEF.md
# Subroutine Call Bus-Cycle Sequencer

This block drives the bus of a small 8-bit processor through the six bus cycles of an absolute subroutine call. It starts from the opcode fetch, reads the two bytes of the target address, spends one cycle on a stack read whose data is ignored, pushes a return address, and then loads the new program counter. The cycle after the last one is the opcode fetch at the target. The bus always reads or writes in every cycle. Cycles that only do internal work issue a read and discard its data, because a stray read is less risky than a stray write toward memory-mapped peripherals.

The sequencer has no dedicated temporary register for the target's low byte. Once the stack address has been copied into the address register, that byte is kept in the stack pointer register. The stack address is decremented for each push, and the running result is held in an arithmetic result latch. It returns to the stack pointer only in the final cycle, at the same moment as the program counter takes the full target. The start input marks the fetch cycle in which the call opcode was decoded. A done pulse flags the cycle that reads the high target byte.

Top module: `jsr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with start low, the block reads (bus_rnw=1) at bus_addr = RST_PC, with pc_out = RST_PC, sp_out = RST_SP and done = 0.
- R2: In the fetch cycle with start low, the program counter and bus address hold their values, and the bus keeps reading.
- R3: Cycle 1, which follows a fetch cycle where start was high, reads the target low byte at fetch address + 1.
- R4: Cycle 2 is a read at {0x01, S} whose data is discarded. At its end S takes the byte read in cycle 1.
- R5: Cycle 3 writes the return high byte to {0x01, S_old}. Cycle 4 writes the return low byte to {0x01, S_old-1}. bus_rnw is 0 in these two cycles and in no other cycle.
- R6: The return address pushed is fetch address + 2 (the address of the last byte of the instruction), and it wraps modulo 2^16.
- R7: Cycle 5 reads the target high byte at fetch address + 2, with done = 1. done is 1 in no other cycle.
- R8: After cycle 5, pc_out = {high byte, low byte} and bus_addr is that target. This is the next fetch.
- R9: After cycle 5, sp_out = S_old - 2. Stack addresses wrap within page 0x01 with no borrow into the high byte (S_old = 0x01 pushes at 0x0101 and then 0x0100, and leaves S = 0xFF).
- R10: pc_out stays at fetch address + 2 from cycle 2 through cycle 5.
- R11: Asserting reset during a call returns the block to the state of R1 on the spot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Call opcode decoded in the current fetch cycle |
| bus_din | input | 8 | Read data from memory |
| bus_addr | output | 16 | Bus address (the address register) |
| bus_dout | output | 8 | Write data (return address bytes) |
| bus_rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| done | output | 1 | High in the cycle that reads the target high byte |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer register |

## Verification
The hardest state to reach is a stack pointer near the bottom of the page, where the pushes must wrap within page 0x01. The bench reset value of the stack pointer is 0x01, so the first call pushes at 0x0101 and 0x0100 and leaves 0xFF. The same first call starts at 0xFFFE, so the fetch address and the return address wrap through 0x0000. A chain of back-to-back calls then brings the stack pointer down further, and a reset in the middle of a push shows that the sequence is abandoned at once.

// File: rtl/jsr_pkg.sv
package jsr_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_OPLO  = 3'd1,
    CYC_DUMMY = 3'd2,
    CYC_PUSHH = 3'd3,
    CYC_PUSHL = 3'd4,
    CYC_OPHI  = 3'd5
  } cyc_e;

  typedef enum logic [1:0] {
    AR_HOLD  = 2'd0,
    AR_PC    = 2'd1,
    AR_STACK = 2'd2,
    AR_DEC   = 2'd3
  } ar_src_e;

  typedef struct packed {
    logic    adv_pc;
    logic    latch_dl;
    logic    ld_s_dl;
    logic    alu_dec;
    logic    ld_target;
    logic    wr;
    logic    push_hi;
    logic    done;
    ar_src_e ar_src;
  } ctl_t;

endpackage

// File: rtl/jsr_seq_ctrl.sv
module jsr_seq_ctrl
  import jsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output cyc_e state_q,
  output ctl_t ctl
);

  cyc_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CYC_FETCH: if (start) state_d = CYC_OPLO;
      CYC_OPLO:  state_d = CYC_DUMMY;
      CYC_DUMMY: state_d = CYC_PUSHH;
      CYC_PUSHH: state_d = CYC_PUSHL;
      CYC_PUSHL: state_d = CYC_OPHI;
      CYC_OPHI:  state_d = CYC_FETCH;
      default:   state_d = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CYC_FETCH;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl        = '0;
    ctl.ar_src = AR_HOLD;
    unique case (state_q)
      CYC_FETCH: begin
        ctl.adv_pc = start;
        ctl.ar_src = AR_PC;
      end
      CYC_OPLO: begin
        ctl.adv_pc   = 1'b1;
        ctl.latch_dl = 1'b1;
        ctl.ar_src   = AR_STACK;
      end
      CYC_DUMMY: begin
        ctl.ld_s_dl = 1'b1;
        ctl.ar_src  = AR_HOLD;
      end
      CYC_PUSHH: begin
        ctl.wr      = 1'b1;
        ctl.push_hi = 1'b1;
        ctl.alu_dec = 1'b1;
        ctl.ar_src  = AR_DEC;
      end
      CYC_PUSHL: begin
        ctl.wr      = 1'b1;
        ctl.alu_dec = 1'b1;
        ctl.ar_src  = AR_PC;
      end
      CYC_OPHI: begin
        ctl.ld_target = 1'b1;
        ctl.done      = 1'b1;
        ctl.ar_src    = AR_PC;
      end
      default: ctl.ar_src = AR_HOLD;
    endcase
  end

endmodule

// File: rtl/jsr_seq_regs.sv
module jsr_seq_regs
  import jsr_pkg::*;
#(
  parameter int                   DATA_W = 8,
  parameter logic [2*DATA_W-1:0]  RST_PC = '0,
  parameter logic [DATA_W-1:0]    RST_SP = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctl_t                ctl,
  input  logic [DATA_W-1:0]   din,
  input  logic [DATA_W-1:0]   ar_lo,
  output logic [2*DATA_W-1:0] pc_q,
  output logic [2*DATA_W-1:0] pc_d,
  output logic [DATA_W-1:0]   s_q
);

  localparam int PC_W = 2 * DATA_W;

  logic [DATA_W-1:0] dl_q, dl_d;
  logic [DATA_W-1:0] alu_q, alu_d;
  logic [DATA_W-1:0] s_d;
  logic              pc_en, dl_en, alu_en, s_en;

  // program counter: increment during operand fetch, full load at the end
  always_comb begin
    pc_en = ctl.adv_pc | ctl.ld_target;
    if (ctl.ld_target)   pc_d = {din, s_q};
    else if (ctl.adv_pc) pc_d = pc_q + PC_W'(1);
    else                 pc_d = pc_q;
  end

  // input data latch holds the low target byte for one cycle
  always_comb begin
    dl_en = ctl.latch_dl;
    dl_d  = din;
  end

  // result latch carries the decrementing stack address
  always_comb begin
    alu_en = ctl.alu_dec;
    alu_d  = ar_lo - DATA_W'(1);
  end

  // stack pointer: parks the low target byte, then takes the result latch
  always_comb begin
    s_en = ctl.ld_s_dl | ctl.ld_target;
    s_d  = ctl.ld_target ? alu_q : dl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RST_PC;
      dl_q  <= '0;
      alu_q <= '0;
      s_q   <= RST_SP;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (dl_en)  dl_q  <= dl_d;
      if (alu_en) alu_q <= alu_d;
      if (s_en)   s_q   <= s_d;
    end
  end

endmodule

// File: rtl/jsr_seq_addr.sv
module jsr_seq_addr
  import jsr_pkg::*;
#(
  parameter int                  DATA_W     = 8,
  parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
  parameter logic [2*DATA_W-1:0] RST_PC     = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctl_t                ctl,
  input  logic [2*DATA_W-1:0] pc_d,
  input  logic [2*DATA_W-1:0] pc_q,
  input  logic [DATA_W-1:0]   s_q,
  output logic [2*DATA_W-1:0] ar_q,
  output logic [DATA_W-1:0]   dout,
  output logic                rnw
);

  localparam int PC_W = 2 * DATA_W;

  logic [PC_W-1:0] ar_d;
  logic            ar_en;

  always_comb begin
    ar_en = (ctl.ar_src != AR_HOLD);
    unique case (ctl.ar_src)
      AR_PC:    ar_d = pc_d;
      AR_STACK: ar_d = {STACK_PAGE, s_q};
      AR_DEC:   ar_d = {STACK_PAGE, ar_q[DATA_W-1:0] - DATA_W'(1)};
      default:  ar_d = ar_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ar_q <= RST_PC;
    else if (ar_en) ar_q <= ar_d;
  end

  always_comb begin
    rnw = ~ctl.wr;
    if (!ctl.wr)          dout = '0;
    else if (ctl.push_hi) dout = pc_q[PC_W-1:DATA_W];
    else                  dout = pc_q[DATA_W-1:0];
  end

endmodule

// File: rtl/jsr_seq.sv
module jsr_seq
  import jsr_pkg::*;
#(
  parameter logic [15:0] RST_PC     = 16'h0000,
  parameter logic [7:0]  RST_SP     = 8'hFD,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  bus_din,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_dout,
  output logic        bus_rnw,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out
);

  localparam int DATA_W = 8;
  localparam int PC_W   = 2 * DATA_W;

  cyc_e            state_q;
  ctl_t            ctl;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] s_q;

  jsr_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .state_q (state_q),
    .ctl     (ctl)
  );

  jsr_seq_regs #(
    .DATA_W (DATA_W),
    .RST_PC (RST_PC),
    .RST_SP (RST_SP)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .din   (bus_din),
    .ar_lo (bus_addr[DATA_W-1:0]),
    .pc_q  (pc_q),
    .pc_d  (pc_d),
    .s_q   (s_q)
  );

  jsr_seq_addr #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .RST_PC     (RST_PC)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .pc_d  (pc_d),
    .pc_q  (pc_q),
    .s_q   (s_q),
    .ar_q  (bus_addr),
    .dout  (bus_dout),
    .rnw   (bus_rnw)
  );

  assign done   = ctl.done;
  assign pc_out = pc_q;
  assign sp_out = s_q;

endmodule

// File: rtl/jsr_seq_chk.sv
module jsr_seq_chk
  import jsr_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input cyc_e        state_q,
  input logic [7:0]  bus_din,
  input logic [15:0] bus_addr,
  input logic        bus_rnw,
  input logic        done,
  input logic [15:0] pc_out,
  input logic [7:0]  sp_out
);

  AST_WRITE_IN_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rnw |-> bus_addr[15:8] == STACK_PAGE); // R5

  AST_TWO_WRITES_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!$past(bus_rnw) && !$past(bus_rnw, 2) && $past(bus_rnw, 3))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_PC_HELD_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rnw |-> $stable(pc_out)); // R10

  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pc_out == {$past(bus_din), $past(sp_out)}); // R8

  AST_SP_MINUS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sp_out == 8'($past(bus_addr[7:0], 3) - 8'd2)); // R9

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CYC_FETCH && !start) |=> ($stable(pc_out) && bus_rnw)); // R2

endmodule

bind jsr_seq jsr_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .state_q  (state_q),
  .bus_din  (bus_din),
  .bus_addr (bus_addr),
  .bus_rnw  (bus_rnw),
  .done     (done),
  .pc_out   (pc_out),
  .sp_out   (sp_out)
);

// File: tb/jsr_seq_tb.sv
module jsr_seq_tb;

  localparam logic [15:0] T_RST_PC = 16'hFFFE;
  localparam logic [7:0]  T_RST_SP = 8'h01;
  localparam int          NVEC     = 6;
  localparam logic [15:0] TARGETS [NVEC] = '{
    16'h1234, 16'h80FF, 16'h00FE, 16'hFFFE, 16'h4000, 16'hA5C3
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  bus_din;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_rnw;
  logic        done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_pc;
  logic [7:0]  m_sp;

  always #5 clk = ~clk;

  jsr_seq #(.RST_PC(T_RST_PC), .RST_SP(T_RST_SP)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_din  (bus_din),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_rnw  (bus_rnw),
    .done     (done),
    .pc_out   (pc_out),
    .sp_out   (sp_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Entered at a negedge in the fetch cycle; leaves at the negedge of the next fetch.
  task automatic do_call(input logic [15:0] tgt);
    logic [15:0] ret;
    logic [7:0]  s0;
    ret = m_pc + 16'd2;
    s0  = m_sp;
    chk("R2 fetch addr", 32'(bus_addr), 32'(m_pc));
    chk("R5 fetch is read", 32'(bus_rnw), 32'd1);
    start = 1'b1; bus_din = 8'h20;
    @(negedge clk);
    start = 1'b0;
    chk("R3 low operand addr", 32'(bus_addr), 32'(m_pc + 16'd1));
    chk("R5 cycle1 read", 32'(bus_rnw), 32'd1);
    bus_din = tgt[7:0];
    @(negedge clk);
    chk("R4 dummy read addr", 32'(bus_addr), 32'({8'h01, s0}));
    chk("R4 dummy is read", 32'(bus_rnw), 32'd1);
    chk("R10 pc cycle2", 32'(pc_out), 32'(ret));
    bus_din = 8'hA5;
    @(negedge clk);
    chk("R5 push hi write", 32'(bus_rnw), 32'd0);
    chk("R5 push hi addr", 32'(bus_addr), 32'({8'h01, s0}));
    chk("R6 push hi data", 32'(bus_dout), 32'(ret[15:8]));
    chk("R4 S parks low byte", 32'(sp_out), 32'(tgt[7:0]));
    @(negedge clk);
    chk("R5 push lo write", 32'(bus_rnw), 32'd0);
    chk("R9 push lo addr", 32'(bus_addr), 32'({8'h01, 8'(s0 - 8'd1)}));
    chk("R6 push lo data", 32'(bus_dout), 32'(ret[7:0]));
    chk("R10 pc cycle4", 32'(pc_out), 32'(ret));
    @(negedge clk);
    chk("R7 high operand addr", 32'(bus_addr), 32'(ret));
    chk("R7 done high", 32'(done), 32'd1);
    chk("R7 cycle5 read", 32'(bus_rnw), 32'd1);
    bus_din = tgt[15:8];
    @(negedge clk);
    chk("R8 new pc", 32'(pc_out), 32'(tgt));
    chk("R8 next fetch addr", 32'(bus_addr), 32'(tgt));
    chk("R9 sp minus two", 32'(sp_out), 32'(8'(s0 - 8'd2)));
    chk("R7 done single", 32'(done), 32'd0);
    m_pc = tgt;
    m_sp = 8'(s0 - 8'd2);
  endtask

  task automatic chk_reset_state(input string req);
    chk(req, 32'(bus_addr), 32'(T_RST_PC));
    chk(req, 32'(pc_out), 32'(T_RST_PC));
    chk(req, 32'(sp_out), 32'(T_RST_SP));
    chk(req, 32'(bus_rnw), 32'd1);
    chk(req, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bus_din = 8'h00;
    repeat (3) @(negedge clk);
    chk_reset_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 after release");

    // R2: idle fetch cycles without start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 idle addr", 32'(bus_addr), 32'(T_RST_PC));
      chk("R2 idle pc", 32'(pc_out), 32'(T_RST_PC));
      chk("R2 idle read", 32'(bus_rnw), 32'd1);
    end

    m_pc = T_RST_PC;
    m_sp = T_RST_SP;
    // vector walk: first call covers PC wrap (R6) and stack page wrap (R9)
    for (int v = 0; v < NVEC; v++) do_call(TARGETS[v]);

    // R11: reset in the middle of a push
    start = 1'b1; bus_din = 8'h20;
    @(negedge clk); start = 1'b0; bus_din = 8'h77;
    @(negedge clk);
    @(negedge clk);
    chk("R11 in push before reset", 32'(bus_rnw), 32'd0);
    rst_n = 1'b0;
    #1;
    chk_reset_state("R11 reset mid call");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R11 after release");
    m_pc = T_RST_PC;
    m_sp = T_RST_SP;
    do_call(16'h0203);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule